// File: doc/BRIEF.md
# Time-Shared Loss-of-Signal Supervisor

This block watches several serial data channels for missing transition activity using only one detector. The detector visits the channels in a fixed rotation. On each channel it stays for a dwell window of a set number of reference clock cycles. The analog front end gives each channel one strobe bit, which pulses whenever that channel's data transitions. If the visited channel's strobe stays quiet for the whole window, that channel's loss latch is set.

Each latch is sticky. It drives an active-low per-channel indicator and stays set until an explicit clear arrives. The clear acts on the latches at once, without waiting for a clock edge. Its release is resynchronised to the reference clock, and the window of the channel under inspection then starts again from zero. A masked OR of the latches drives a pull-down enable for an open-drain alarm line that several devices can share. While fast acquisition is active, detection is suspended and no latch can be set.

Top module: `los_scan_monitor`

## Requirements
- R1: The detector visits channels in ascending index order and wraps from the last channel to channel 0. It spends exactly DWELL_CYCLES clock cycles on each channel, and channel 0 is the first one visited after reset.
- R2: A channel passes its window if its own strobe bit (bit i of `act_strobe` for channel i) is high on at least one clock edge of that window. Otherwise its latch is set on the window's last edge. After reset with all strobes low, channel 0's latch sets on exactly the DWELL_CYCLES-th rising edge, and channel 1's latch sets DWELL_CYCLES edges later.
- R3: `loss_n[i]` is low exactly when channel i's latch is set.
- R4: A set latch stays set when activity returns. Only a clear or a reset removes it.
- R5: While `clr_async` is high, all latches read clear and the alarm is released, with no clock edge needed.
- R6: After `clr_async` falls and its two-flop release has passed, scanning resumes. A channel that is still silent sets its latch again within two rotations.
- R7: While `fastlock` is high, no latch becomes set, whatever the strobes do.
- R8: `los_alarm_pd` (1 = pull the shared line low) is high exactly when some channel i has its latch set and `alarm_mask[i]` low. When all mask bits are high, it never asserts.
- R9: A change on `alarm_mask` reaches `los_alarm_pd` in the same cycle and leaves the latches and `loss_n` unchanged.
- R10: When reset is active, all latches clear, `loss_n` reads all ones, `los_alarm_pd` is low, and the scan restarts at channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_strobe | input | NUM_CH | Per-channel transition strobes, bit i for channel i |
| clr_async | input | 1 | Active-high asynchronous clear of all latches |
| fastlock | input | 1 | Fast acquisition active; suspends detection |
| alarm_mask | input | NUM_CH | Bit i high removes channel i from the alarm |
| loss_n | output | NUM_CH | Active-low per-channel loss indicators |
| los_alarm_pd | output | 1 | Pull-down enable for the shared open-drain alarm |

## Verification
On every cycle, the embedded assertions check the following:
- The rotation advances by exactly one channel at each window end.
- No more than one latch is set per edge.
- No latch sets while fast acquisition is high.
- Latches never fall except under a clear.
- A fully masked alarm stays released.

Other behaviour shows only in the bench's scenarios:
- The exact edge on which a silent channel's verdict lands.
- A single strobe pulse being enough to pass a window.
- The clear acting between clock edges.
- Latches re-arming after a clear.
- Mask changes leaving the indicators untouched.

// File: rtl/los_pkg.sv
package los_pkg;
   // Width of an index that can name any of n items (at least 1 bit).
   function automatic int unsigned idx_w(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/los_clear_sync.sv
module los_clear_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_async,
   output logic clr_hold
);
   initial begin
      if (STAGES < 2) $error("los_clear_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;

   // Assertion is immediate; release walks through STAGES flops.
   always_ff @(posedge clk or posedge clr_async or negedge rst_n) begin
      if (!rst_n)
         sh_q <= '0;
      else if (clr_async)
         sh_q <= '1;
      else
         sh_q <= {sh_q[STAGES-2:0], 1'b0};
   end

   assign clr_hold = sh_q[STAGES-1];

   // R6: once raised, the hold cannot drop while the clear input stays high
   a_r6_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_async && clr_hold) |=> clr_hold);
endmodule

// File: rtl/los_scan_sched.sv
module los_scan_sched
   import los_pkg::*;
#(
   parameter int unsigned NUM_CH       = 4,
   parameter int unsigned DWELL_CYCLES = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            hold,
   input  logic [NUM_CH-1:0]               act_strobe,
   output logic [idx_w(NUM_CH)-1:0]        ch_idx,
   output logic                            verdict,
   output logic                            lost
);
   localparam int unsigned IW = idx_w(NUM_CH);
   localparam int unsigned CW = idx_w(DWELL_CYCLES);
   localparam logic [CW-1:0] CNT_LAST = CW'(DWELL_CYCLES - 1);
   localparam logic [IW-1:0] CH_LAST  = IW'(NUM_CH - 1);

   initial begin
      if (DWELL_CYCLES < 2) $error("los_scan_sched: DWELL_CYCLES must be at least 2");
      if (NUM_CH < 2)       $error("los_scan_sched: NUM_CH must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic [IW-1:0] ch_q;
   logic          seen_q;
   logic          sel_act;
   logic          last;

   assign sel_act = act_strobe[ch_q];
   assign last    = (cnt_q == CNT_LAST);
   assign verdict = last && !hold;
   assign lost    = verdict && !(seen_q || sel_act);
   assign ch_idx  = ch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         ch_q   <= '0;
         seen_q <= 1'b0;
      end else if (hold) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (last) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
         ch_q   <= (ch_q == CH_LAST) ? '0 : ch_q + 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         seen_q <= seen_q || sel_act;
      end
   end

   // R1: each verdict moves the rotation on by exactly one channel
   a_r1_rotation_step: assert property (@(posedge clk) disable iff (!rst_n)
      verdict |=> (ch_q == (($past(ch_q) == CH_LAST) ? '0 : $past(ch_q) + 1'b1)));

   // R1: outside a verdict the visited channel does not move
   a_r1_channel_steady: assert property (@(posedge clk) disable iff (!rst_n)
      !verdict |=> $stable(ch_q));

   // R7: a held scan yields no verdict
   a_r7_hold_no_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> !lost);
endmodule

// File: rtl/los_latch_bank.sv
module los_latch_bank
   import los_pkg::*;
#(
   parameter int unsigned NUM_CH = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_async,
   input  logic                     clr_hold,
   input  logic                     fastlock,
   input  logic                     lost,
   input  logic [idx_w(NUM_CH)-1:0] ch_idx,
   input  logic [NUM_CH-1:0]        alarm_mask,
   output logic [NUM_CH-1:0]        latch_q,
   output logic                     alarm_pd
);
   localparam int unsigned IW = idx_w(NUM_CH);

   logic [NUM_CH-1:0] set_vec;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign set_vec[i] = lost && (ch_idx == IW'(i));

      always_ff @(posedge clk or negedge rst_n or posedge clr_async) begin
         if (!rst_n)
            latch_q[i] <= 1'b0;
         else if (clr_async)
            latch_q[i] <= 1'b0;
         else if (clr_hold)
            latch_q[i] <= 1'b0;
         else if (set_vec[i])
            latch_q[i] <= 1'b1;
      end
   end

   assign alarm_pd = |(latch_q & ~alarm_mask);

   // R2: at most one channel is judged per edge
   a_r2_single_set: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_vec));

   // R4: latches only fall under a clear
   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n || clr_async)
      !clr_hold |=> (clr_hold || (($past(latch_q) & ~latch_q) == '0)));

   // R7: no latch rises while fast acquisition was high at the edge
   a_r7_fastlock_no_set: assert property (@(posedge clk) disable iff (!rst_n || clr_async)
      fastlock |=> ((latch_q & ~$past(latch_q)) == '0));

   // R8: a fully masked alarm never pulls the line
   a_r8_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (&alarm_mask) |-> !alarm_pd);
endmodule

// File: rtl/los_scan_monitor.sv
module los_scan_monitor
   import los_pkg::*;
#(
   parameter int unsigned NUM_CH       = 4,
   parameter int unsigned DWELL_CYCLES = 16,
   parameter int unsigned CLR_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] act_strobe,
   input  logic              clr_async,
   input  logic              fastlock,
   input  logic [NUM_CH-1:0] alarm_mask,
   output logic [NUM_CH-1:0] loss_n,
   output logic              los_alarm_pd
);
   localparam int unsigned IW = idx_w(NUM_CH);

   logic          clr_hold;
   logic          scan_hold;
   logic [IW-1:0] ch_idx;
   logic          verdict;
   logic          lost;
   logic [NUM_CH-1:0] latch_q;

   los_clear_sync #(.STAGES(CLR_STAGES)) u_clr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_async (clr_async),
      .clr_hold  (clr_hold)
   );

   assign scan_hold = clr_hold || fastlock;

   los_scan_sched #(.NUM_CH(NUM_CH), .DWELL_CYCLES(DWELL_CYCLES)) u_sched (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold       (scan_hold),
      .act_strobe (act_strobe),
      .ch_idx     (ch_idx),
      .verdict    (verdict),
      .lost       (lost)
   );

   los_latch_bank #(.NUM_CH(NUM_CH)) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_async  (clr_async),
      .clr_hold   (clr_hold),
      .fastlock   (fastlock),
      .lost       (lost),
      .ch_idx     (ch_idx),
      .alarm_mask (alarm_mask),
      .latch_q    (latch_q),
      .alarm_pd   (los_alarm_pd)
   );

   assign loss_n = ~latch_q;

   // R5: during a clear every indicator reads inactive
   a_r5_clear_indicators: assert property (@(posedge clk) disable iff (!rst_n)
      clr_async |-> (&loss_n && !los_alarm_pd));
endmodule

// File: tb/los_scan_monitor_tb.sv
module los_scan_monitor_tb;
   localparam int NCH   = 4;
   localparam int DWELL = 16;
   localparam int ROT   = NCH * DWELL;
   localparam int SETTLE = 2 * ROT + 8;

   typedef struct packed {
      logic [3:0] act;
      logic [3:0] mask;
      logic [3:0] exp_ln;
      logic       exp_al;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{4'hF, 4'h0, 4'hF, 1'b0},
      '{4'hE, 4'h0, 4'hE, 1'b1},
      '{4'h5, 4'h0, 4'h5, 1'b1},
      '{4'h5, 4'hA, 4'h5, 1'b0},
      '{4'h0, 4'hF, 4'h0, 1'b0},
      '{4'h0, 4'h7, 4'h0, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0] act_strobe = '0;
   logic clr_async = 1'b0;
   logic fastlock = 1'b0;
   logic [NCH-1:0] alarm_mask = '0;
   logic [NCH-1:0] loss_n;
   logic los_alarm_pd;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   los_scan_monitor #(.NUM_CH(NCH), .DWELL_CYCLES(DWELL)) u_dut (
      .clk(clk), .rst_n(rst_n), .act_strobe(act_strobe), .clr_async(clr_async),
      .fastlock(fastlock), .alarm_mask(alarm_mask), .loss_n(loss_n),
      .los_alarm_pd(los_alarm_pd)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic check(input string req, input logic [3:0] exp_ln, input logic exp_al);
      checks++;
      if (loss_n !== exp_ln || los_alarm_pd !== exp_al) begin
         failures++;
         $display("FAIL %s: loss_n=%b alarm_pd=%b expected loss_n=%b alarm_pd=%b",
                  req, loss_n, los_alarm_pd, exp_ln, exp_al);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
   endtask

   task automatic pulse_clear();
      clr_async = 1'b1;
      step(3);
      clr_async = 1'b0;
   endtask

   initial begin
      step(1);
      check("R10 reset state", 4'hF, 1'b0);
      do_reset();

      // R2/R1: verdict timing with all channels silent
      step(DWELL - 1);
      check("R2 no verdict before window end", 4'hF, 1'b0);
      step(1);
      check("R2 ch0 set on last window edge", 4'hE, 1'b1);
      step(DWELL);
      check("R1 ch1 judged after ch0", 4'hC, 1'b1);

      // R10: reset restarts scan at channel 0; R2 single pulse passes window
      do_reset();
      check("R10 reset clears latches", 4'hF, 1'b0);
      step(3);
      act_strobe = 4'h1;
      step(1);
      act_strobe = 4'h0;
      step(DWELL - 4);
      check("R2 single strobe keeps ch0 clear", 4'hF, 1'b0);
      step(DWELL);
      check("R1 ch1 lost after ch0 window", 4'hD, 1'b1);

      // Table walk: R3/R8 patterns
      for (int v = 0; v < NV; v++) begin
         act_strobe = VECS[v].act;
         alarm_mask = VECS[v].mask;
         pulse_clear();
         step(SETTLE);
         check($sformatf("R3/R8 vector %0d", v), VECS[v].exp_ln, VECS[v].exp_al);
      end

      // R9: mask change is immediate and leaves latches alone
      act_strobe = 4'h5;
      alarm_mask = 4'h0;
      pulse_clear();
      step(SETTLE);
      check("R9 baseline", 4'h5, 1'b1);
      alarm_mask = 4'hA;
      #1;
      check("R9 mask applied same cycle", 4'h5, 1'b0);
      step(3);
      alarm_mask = 4'h0;
      #1;
      check("R9 unmask restores alarm, latches intact", 4'h5, 1'b1);

      // R4: stickiness after activity returns
      act_strobe = 4'hF;
      step(SETTLE);
      check("R4 latches stay set", 4'h5, 1'b1);

      // R5: clear acts between edges
      step(1);
      #1;
      clr_async = 1'b1;
      #1;
      check("R5 async clear without edge", 4'hF, 1'b0);
      step(3);
      act_strobe = 4'h0;
      clr_async = 1'b0;
      step(1);
      check("R6 still clear just after release", 4'hF, 1'b0);
      step(SETTLE);
      check("R6 missing channels set again", 4'h0, 1'b1);

      // R7: fastlock suspends detection
      fastlock = 1'b1;
      pulse_clear();
      step(SETTLE);
      check("R7 no latch during fastlock", 4'hF, 1'b0);
      fastlock = 1'b0;
      step(SETTLE);
      check("R7 detection resumes after fastlock", 4'h0, 1'b1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule